// File: doc/BRIEF.md
# Indirect Tuning Parameter Port

This block gives a host a small register window onto a bank of internal tuning parameters: three traffic-class weights and two buffer-level settings. The host never addresses a parameter directly. It first loads a selector, a pair of codes (a main code and a subcode), into the selector register. It then writes the data register, and that write starts a transaction. The value written decides the direction. A word of all ones asks for a read. Any other word asks for a write of its low 16 bits.

While a transaction is in flight, a busy flag in the status register stays high for a fixed, parameterised number of cycles. The host polls this flag. When it drops, a read result appears in the low 16 bits of the data register, or a written value has reached its parameter. A selector that names no parameter still completes normally. It leaves every parameter alone and reads back as zero.

Register bus: single-cycle writes on `bus_wr` with `bus_addr`/`bus_wdata`; reads are combinational on `bus_addr`. Address 0 is the selector, 1 the data register, 2 the status register, and 3 reads zero.

Top module: `tune_port`

## Requirements
- R1: The selector register at address 0 holds the main code in bits 15:0 and the subcode in bits 23:16; it reads back those 24 bits with bits 31:24 zero.
- R2: Writing 32'hFFFF_FFFF to the data register (address 1) starts a read; once busy clears, the data register reads {16'h0, selected parameter}.
- R3: Writing any other value to the data register starts a write; once busy clears, the selected parameter holds that value's bits 15:0 (so 32'h0000_FFFF stores 16'hFFFF).
- R4: Status bit 0 (address 2) is busy; it is set from the clock edge that accepts the data write and is high for exactly LATENCY clock cycles; other status bits are zero.
- R5: Five selectors each have their own storage: main 4 with subcode 3, 4 or 5, and main 5 with subcode 6 or 7; a write to one leaves the other four unchanged.
- R6: Any other selector completes after the same latency, changes no parameter, and a read of it returns zero.
- R7: Writes to the selector or data register while busy is set are ignored.
- R8: After reset, every parameter, the selector and the data register read zero and busy is clear.
- R9: The data register's value field changes only when a read completes; a write transaction leaves it as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
A sweep writes a distinct value to every main code from 0 to 7 paired with every subcode from 0 to 9, then reads every pair back. This tells the five live selectors apart from each other and from the unsupported ones. It also shows whether a write lands in the wrong slot or a dead selector leaks a value. Boundary data words are tried as well: all ones is a read, while 32'h0000_FFFF and 32'hFFFF_FFFE are writes, so the bench sees whether the direction decode looks at all 32 bits or only the low half. Busy is counted cycle by cycle on every transaction. Writes issued during busy are then checked through the selector readback and the parameter contents.

// File: rtl/tune_port.sv
module tune_port #(
  parameter int LATENCY = 8,
  parameter int VALW    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int NPRM = 5;
  localparam int SELW = 24;
  localparam int CW   = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [1:0] A_SEL = 2'd0, A_DATA = 2'd1, A_STAT = 2'd2;
  localparam logic [2:0] NONE = 3'd7;

  logic [SELW-1:0] sel_q;
  logic            busy_q, rd_op_q;
  logic [VALW-1:0] wval_q, res_q, hit_val;
  logic [CW-1:0]   cnt_q;
  logic [2:0]      idx_q;
  logic [VALW-1:0] prm_q [NPRM];

  function automatic logic [2:0] decode(input logic [SELW-1:0] s);
    case (s)
      {8'd3, 16'd4}: decode = 3'd0;
      {8'd4, 16'd4}: decode = 3'd1;
      {8'd5, 16'd4}: decode = 3'd2;
      {8'd6, 16'd5}: decode = 3'd3;
      {8'd7, 16'd5}: decode = 3'd4;
      default:       decode = NONE;
    endcase
  endfunction

  wire start = bus_wr && !busy_q && bus_addr == A_DATA;
  wire done  = busy_q && cnt_q == '0;

  always_comb begin
    hit_val = '0;
    for (int i = 0; i < NPRM; i++)
      if (idx_q == 3'(i)) hit_val = prm_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      busy_q  <= 1'b0;
      rd_op_q <= 1'b0;
      wval_q  <= '0;
      res_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= NONE;
      for (int i = 0; i < NPRM; i++) prm_q[i] <= '0;
    end else begin
      if (bus_wr && !busy_q && bus_addr == A_SEL) sel_q <= bus_wdata[SELW-1:0];
      if (start) begin
        busy_q  <= 1'b1;
        cnt_q   <= CW'(LATENCY - 1);
        rd_op_q <= &bus_wdata;
        wval_q  <= bus_wdata[VALW-1:0];
        idx_q   <= decode(sel_q);
      end else if (busy_q) begin
        if (done) busy_q <= 1'b0;
        else      cnt_q  <= cnt_q - 1'b1;
      end
      if (done && rd_op_q) res_q <= hit_val;
      for (int i = 0; i < NPRM; i++)
        if (done && !rd_op_q && idx_q == 3'(i)) prm_q[i] <= wval_q;
    end
  end

  always_comb begin
    case (bus_addr)
      A_SEL:   bus_rdata = 32'(sel_q);
      A_DATA:  bus_rdata = 32'(res_q);
      A_STAT:  bus_rdata = {31'd0, busy_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tune_port_chk.sv
module tune_port_chk #(
  parameter int LATENCY = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic        busy,
  input logic [23:0] sel,
  input logic [15:0] res
);
  localparam int RW = $clog2(LATENCY + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  a_r4_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && !busy) |=> busy);

  a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == RW'(LATENCY));

  a_r7_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> $stable(sel));

  a_r9_res_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res) |-> $fell(busy));

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 2'd3) |-> bus_rdata[31:24] == 8'd0);
endmodule

bind tune_port tune_port_chk #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .busy(busy_q), .sel(sel_q), .res(res_q)
);

// File: tb/tune_port_bench.sv
module tune_port_bench;
  localparam int LAT = 8;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  int total = 0, bad = 0;
  logic [15:0] model [8][10];

  tune_port #(.LATENCY(LAT)) u_tune_port (.*);

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: run hung");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic bit live(input int m, input int s);
    return (m == 4 && s >= 3 && s <= 5) || (m == 5 && (s == 6 || s == 7));
  endfunction

  // called right after wr() returns: one negedge after the accepting edge
  task automatic wait_idle(input string tag, input bit check_len);
    logic [31:0] st;
    int n = 0;
    rd(2'd2, st);
    while (st[0]) begin
      n++;
      @(negedge clk);
      rd(2'd2, st);
    end
    if (check_len) chk(tag, n, LAT);
  endtask

  task automatic access(input int m, input int s, input logic [31:0] d,
                        input bit check_len, output logic [31:0] q);
    wr(2'd0, {8'd0, 8'(s), 16'(m)});
    wr(2'd1, d);
    wait_idle("R4 busy length", check_len);
    rd(2'd1, q);
  endtask

  initial begin
    logic [31:0] q, prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    rd(2'd0, q); chk("R8 selector reset", q, 0);
    rd(2'd1, q); chk("R8 data reset", q, 0);
    rd(2'd2, q); chk("R8 status reset", q, 0);
    rd(2'd3, q); chk("R8 spare address", q, 0);
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 10; s++) model[m][s] = 0;
    for (int m = 3; m < 6; m++)
      for (int s = 0; s < 10; s++) begin
        access(m, s, 32'hFFFF_FFFF, 0, q);
        chk("R8 parameter reset", q, 0);
      end
    // R1 selector layout
    wr(2'd0, 32'hABCD_1234);
    rd(2'd0, q); chk("R1 selector readback", q, 32'h00CD_1234);
    // R4 busy visible and bit layout
    wr(2'd0, {8'd0, 8'd3, 16'd4});
    wr(2'd1, 32'h0000_0011);
    rd(2'd2, q); chk("R4 status busy", q, 1);
    wait_idle("R4 busy length", 1);
    // sweep writes, R3 R5 R6 R9
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 10; s++) begin
        logic [15:0] v = 16'(m * 256 + s * 16 + 5);
        rd(2'd1, prev);
        access(m, s, {16'h5A00, v}, (m == 4 && s == 0), q);
        chk("R9 data unchanged by write", q, prev);
        if (live(m, s)) model[m][s] = v;
      end
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 10; s++) begin
        access(m, s, 32'hFFFF_FFFF, (m == 5 && s == 7), q);
        if (live(m, s)) chk("R5 R2 live selector read", q, {16'h0, model[m][s]});
        else            chk("R6 dead selector reads zero", q, 0);
      end
    // R3 boundary data words
    access(5, 6, 32'h0000_FFFF, 0, q);
    access(5, 6, 32'hFFFF_FFFF, 0, q);
    chk("R3 low-half all ones is a write", q, 32'h0000_FFFF);
    access(4, 5, 32'hFFFF_FFFE, 0, q);
    access(4, 5, 32'hFFFF_FFFF, 0, q);
    chk("R3 near all ones is a write", q, 32'h0000_FFFE);
    access(4, 4, 32'hFFFF_FFFF, 0, q);
    chk("R5 neighbour untouched", q, {16'h0, model[4][4]});
    // R7 writes during busy ignored
    wr(2'd0, {8'd0, 8'd3, 16'd4});
    wr(2'd1, 32'h0000_1111);
    wr(2'd0, {8'd0, 8'd7, 16'd5});
    wr(2'd1, 32'h0000_2222);
    wait_idle("R4 busy length", 0);
    rd(2'd0, q); chk("R7 selector write ignored", q, {8'd0, 8'd3, 16'd4});
    access(4, 3, 32'hFFFF_FFFF, 0, q);
    chk("R7 first write landed", q, 32'h0000_1111);
    access(5, 7, 32'hFFFF_FFFF, 0, q);
    chk("R7 data write ignored", q, {16'h0, model[5][7]});
    // R7 read request ignored during busy
    wr(2'd0, {8'd0, 8'd6, 16'd5});
    wr(2'd1, 32'h0000_3333);
    wr(2'd1, 32'hFFFF_FFFF);
    wait_idle("R4 busy length", 0);
    rd(2'd1, q); chk("R7 read during busy ignored", q, {16'h0, model[5][7]});
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule